// File: doc/BRIEF.md
# Reference lock state controller

This block sequences a timing DPLL through its operating states: free-run, pre-locked, locked, holdover and pre-locked2. It watches a lock indication from the phase detector, a flag saying a valid reference is selected and applied to the loop, an alarm on the active reference, a flag saying a higher-priority reference has come back, a revertive-mode enable and a one-second tick. It drives a 3-bit state code for a status register, and a one-cycle request asking the reference selector to choose another source.

The pre-locked2 state is where the loop tries to regain lock after holdover or after a revertive switch. A lock attempt there is limited to a parameterised number of seconds (100 by default), counted in ticks. If the attempt runs out of time, the controller falls back to holdover and requests a new reference.

Top module: `ref_lock_ctrl`

## Requirements
- R1: While reset is held low at a clock edge, the state code becomes 3'b000 (free-run) and reselect_req becomes 0.
- R2: In free-run (3'b000), ref_valid high moves the state to pre-locked (3'b010) on the next clock. Without ref_valid the state stays in free-run.
- R3: In pre-locked (3'b010), lock_ind high moves the state to locked (3'b100) on the next clock.
- R4: In pre-locked, ref_alarm high moves the state back to free-run (3'b000) on the next clock. This takes priority over lock_ind.
- R5: In locked (3'b100), ref_alarm high moves the state to holdover (3'b001) on the next clock. This takes priority over a revertive switch.
- R6: In holdover (3'b001), ref_valid high with ref_alarm low moves the state to pre-locked2 (3'b011) on the next clock. With ref_alarm high the state stays in holdover.
- R7: In locked, revert_en high together with prio_restored high and ref_alarm low moves the state to pre-locked2 on the next clock. With revert_en low the state stays locked.
- R8: In pre-locked2, lock_ind high moves the state to locked on the next clock. This includes the cycle of the final tick, because lock takes priority over the timeout.
- R9: In pre-locked2, without lock or alarm, the TIMEOUT_S-th sec_tick counted since the latest entry moves the state to holdover. Ticks are counted only in pre-locked2, and the count restarts from zero on every entry to that state.
- R10: reselect_req is high for exactly one cycle, in the same cycle the state code first shows holdover after a timeout. It is 0 at all other times.
- R11: In pre-locked2, ref_alarm high moves the state to holdover on the next clock and does not raise reselect_req.
- R12: The state code only ever takes the values 000, 001, 010, 011 and 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lock_ind | input | 1 | Phase detector reports lock |
| ref_valid | input | 1 | A valid reference is selected and applied to the loop |
| ref_alarm | input | 1 | Activity or frequency alarm on the active reference |
| prio_restored | input | 1 | A higher-priority reference has been restored |
| revert_en | input | 1 | Revertive mode enabled |
| sec_tick | input | 1 | One-cycle pulse once per second |
| state_code | output | 3 | Current state for the status register |
| reselect_req | output | 1 | One-cycle request to select another reference |

## Verification
The assertions check four things on every cycle: that the state code is legal, that an alarm in locked always lands in holdover, that free-run leaves only for pre-locked, and that the reselect request is a single pulse which appears only as pre-locked2 gives way to holdover. The tick counter is also checked to stay below its limit. Only the bench scenarios can show that the timeout lands on exactly the hundredth tick and not the ninety-ninth. The scenarios also show that the count restarts after the controller leaves pre-locked2 and comes back, and that the priorities between lock, alarm and timeout resolve as required.

// File: rtl/ref_lock_pkg.sv
// Package: shared state encoding for the reference lock controller.
// Assumes: the encoding is read directly by a software status register.
package ref_lock_pkg;
    typedef enum logic [2:0] {
        ST_FREE   = 3'b000,
        ST_HOLD   = 3'b001,
        ST_PRE    = 3'b010,
        ST_PRE2   = 3'b011,
        ST_LOCKED = 3'b100
    } lock_state_t;
endpackage

// File: rtl/ref_lock_timer.sv
// Module: ref_lock_timer
// Counts one-second ticks while the controller sits in pre-locked2 and
// flags the tick that completes the lock window.
// Assumes: sec_tick is a single-cycle pulse, and in_window drops no later
// than one clock after expired is raised.
module ref_lock_timer #(
    parameter int TIMEOUT_S = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_window,
    input  logic sec_tick,
    output logic expired
);
    localparam int CNT_W = (TIMEOUT_S > 1) ? $clog2(TIMEOUT_S) : 1;

    logic [CNT_W-1:0] cnt_q;

    // Flag the tick that would complete the window.
    always_comb begin
        expired = in_window && sec_tick && (cnt_q == CNT_W'(TIMEOUT_S - 1));
    end

    // Tick counter, cleared whenever the controller is outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_window) begin
            cnt_q <= '0;
        end else if (sec_tick && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < TIMEOUT_S);
endmodule

// File: rtl/ref_lock_seq.sv
// Module: ref_lock_seq
// Next-state logic and state register of the lock controller, plus the
// registered reselect request raised when the pre-locked2 window expires.
// Assumes: the inputs are synchronous to clk, and expired comes from
// ref_lock_timer driven by this module's in_window output.
module ref_lock_seq
    import ref_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_ind,
    input  logic        ref_valid,
    input  logic        ref_alarm,
    input  logic        prio_restored,
    input  logic        revert_en,
    input  logic        expired,
    output logic        in_window,
    output lock_state_t state_q,
    output logic        reselect_q
);
    lock_state_t state_d;
    logic        timeout_hit;

    // Window flag for the timer.
    always_comb begin
        in_window = (state_q == ST_PRE2);
    end

    // Next-state selection with alarm > lock > timeout priority.
    always_comb begin
        state_d     = state_q;
        timeout_hit = 1'b0;
        case (state_q)
            ST_FREE: begin
                if (ref_valid) state_d = ST_PRE;
            end
            ST_PRE: begin
                if (ref_alarm)     state_d = ST_FREE;
                else if (lock_ind) state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (ref_alarm)                       state_d = ST_HOLD;
                else if (revert_en && prio_restored) state_d = ST_PRE2;
            end
            ST_HOLD: begin
                if (ref_valid && !ref_alarm) state_d = ST_PRE2;
            end
            ST_PRE2: begin
                if (ref_alarm)     state_d = ST_HOLD;
                else if (lock_ind) state_d = ST_LOCKED;
                else if (expired) begin
                    state_d     = ST_HOLD;
                    timeout_hit = 1'b1;
                end
            end
            default: state_d = ST_FREE;
        endcase
    end

    // State and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_FREE;
            reselect_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            reselect_q <= timeout_hit;
        end
    end

    // R12
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_FREE, ST_HOLD, ST_PRE, ST_PRE2, ST_LOCKED});

    // R5
    locked_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && ref_alarm) |=> (state_q == ST_HOLD));

    // R2
    free_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE) |=> (state_q == ST_FREE || state_q == ST_PRE));

    // R10
    reselect_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reselect_q |-> (state_q == ST_HOLD && $past(state_q) == ST_PRE2));

    // R10
    reselect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reselect_q |=> !reselect_q);
endmodule

// File: rtl/ref_lock_ctrl.sv
// Module: ref_lock_ctrl (top)
// Reference lock state controller for a timing DPLL. Ties the state
// sequencer to the pre-locked2 timeout counter and presents the state code
// and the reselect request.
// Assumes: all inputs are synchronous to clk, and sec_tick pulses for one
// cycle per second.
module ref_lock_ctrl #(
    parameter int TIMEOUT_S = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock_ind,
    input  logic       ref_valid,
    input  logic       ref_alarm,
    input  logic       prio_restored,
    input  logic       revert_en,
    input  logic       sec_tick,
    output logic [2:0] state_code,
    output logic       reselect_req
);
    import ref_lock_pkg::*;

    lock_state_t st;
    logic        in_window;
    logic        expired;
    logic        resel;

    ref_lock_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .lock_ind      (lock_ind),
        .ref_valid     (ref_valid),
        .ref_alarm     (ref_alarm),
        .prio_restored (prio_restored),
        .revert_en     (revert_en),
        .expired       (expired),
        .in_window     (in_window),
        .state_q       (st),
        .reselect_q    (resel)
    );

    ref_lock_timer #(.TIMEOUT_S(TIMEOUT_S)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_window (in_window),
        .sec_tick  (sec_tick),
        .expired   (expired)
    );

    // Output mapping.
    always_comb begin
        state_code   = st;
        reselect_req = resel;
    end
endmodule

// File: tb/ref_lock_ctrl_bench.sv
module ref_lock_ctrl_bench;
    localparam int TMO = 100;
    localparam logic [2:0] C_FREE = 3'b000, C_HOLD = 3'b001, C_PRE = 3'b010,
                           C_PRE2 = 3'b011, C_LOCK = 3'b100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_ind = 0, ref_valid = 0, ref_alarm = 0, prio_restored = 0;
    logic revert_en = 0, sec_tick = 0;
    logic [2:0] state_code;
    logic reselect_req;
    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ref_lock_ctrl #(.TIMEOUT_S(TMO)) u_ref_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .lock_ind(lock_ind), .ref_valid(ref_valid),
        .ref_alarm(ref_alarm), .prio_restored(prio_restored),
        .revert_en(revert_en), .sec_tick(sec_tick),
        .state_code(state_code), .reselect_req(reselect_req)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [2:0] exp_st, logic exp_rs);
        checks++;
        if (state_code !== exp_st || reselect_req !== exp_rs) begin
            failures++;
            $display("FAIL %s: state=%b reselect=%b expected state=%b reselect=%b",
                     req, state_code, reselect_req, exp_st, exp_rs);
        end
    endtask

    task automatic clear_inputs();
        lock_ind = 0; ref_valid = 0; ref_alarm = 0;
        prio_restored = 0; revert_en = 0; sec_tick = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
    endtask

    task automatic go_locked();
        do_reset();
        ref_valid = 1; step();
        ref_valid = 0; lock_ind = 1; step();
        lock_ind = 0;
    endtask

    task automatic go_hold();
        go_locked();
        ref_alarm = 1; step();
        ref_alarm = 0;
    endtask

    task automatic go_pre2();
        go_hold();
        ref_valid = 1; step();
        ref_valid = 0;
    endtask

    task automatic t_reset();
        go_locked();
        do_reset();
        check("R1 reset state", C_FREE, 1'b0);
    endtask

    task automatic t_free();
        do_reset();
        step();
        check("R2 free-run holds without ref_valid", C_FREE, 1'b0);
        ref_valid = 1; step(); ref_valid = 0;
        check("R2 free-run to pre-locked", C_PRE, 1'b0);
    endtask

    task automatic t_pre();
        do_reset();
        ref_valid = 1; step(); ref_valid = 0;
        lock_ind = 1; step(); lock_ind = 0;
        check("R3 pre-locked to locked", C_LOCK, 1'b0);
        do_reset();
        ref_valid = 1; step(); ref_valid = 0;
        ref_alarm = 1; lock_ind = 1; step(); clear_inputs();
        check("R4 pre-locked alarm to free-run", C_FREE, 1'b0);
    endtask

    task automatic t_locked_alarm();
        go_locked();
        revert_en = 1; prio_restored = 1; ref_alarm = 1; step(); clear_inputs();
        check("R5 locked alarm to holdover", C_HOLD, 1'b0);
    endtask

    task automatic t_hold();
        go_hold();
        ref_valid = 1; ref_alarm = 1; step();
        check("R6 holdover stays while alarm", C_HOLD, 1'b0);
        ref_alarm = 0; step(); ref_valid = 0;
        check("R6 holdover to pre-locked2", C_PRE2, 1'b0);
    endtask

    task automatic t_revert();
        go_locked();
        prio_restored = 1; step();
        check("R7 no revert when disabled", C_LOCK, 1'b0);
        revert_en = 1; step(); clear_inputs();
        check("R7 revertive switch to pre-locked2", C_PRE2, 1'b0);
    endtask

    task automatic t_pre2_lock();
        go_pre2();
        sec_tick = 1;
        repeat (TMO - 1) step();
        lock_ind = 1; step(); clear_inputs();
        check("R8 lock wins over final tick", C_LOCK, 1'b0);
    endtask

    task automatic t_timeout();
        go_pre2();
        sec_tick = 1;
        repeat (TMO - 1) step();
        check("R9 still pre-locked2 after one tick short", C_PRE2, 1'b0);
        step(); sec_tick = 0;
        check("R9 R10 timeout to holdover with reselect", C_HOLD, 1'b1);
        step();
        check("R10 reselect is a single pulse", C_HOLD, 1'b0);
    endtask

    task automatic t_restart();
        go_pre2();
        sec_tick = 1;
        repeat (TMO - 1) step();
        sec_tick = 0; ref_alarm = 1; step(); ref_alarm = 0;
        check("R11 pre-locked2 alarm to holdover without reselect", C_HOLD, 1'b0);
        ref_valid = 1; step(); ref_valid = 0;
        sec_tick = 1;
        repeat (TMO - 1) step();
        check("R9 count restarts on re-entry", C_PRE2, 1'b0);
        step(); sec_tick = 0;
        check("R9 timeout after fresh full window", C_HOLD, 1'b1);
    endtask

    task automatic t_idle_ticks();
        go_locked();
        sec_tick = 1;
        repeat (TMO + 5) step();
        sec_tick = 0;
        check("R10 no reselect outside pre-locked2", C_LOCK, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_free();
        t_pre();
        t_locked_alarm();
        t_hold();
        t_revert();
        t_pre2_lock();
        t_timeout();
        t_restart();
        t_idle_ticks();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule